// File: doc/BRIEF.md
# I2C Bus Condition and Arbitration Monitor

This block sits beside an I2C controller and watches the two bus lines after they pass a synchronizer. It reports START and STOP conditions as single-cycle pulses and keeps a busy flag covering the time between a START and the next STOP. It also keeps a sticky arbitration-lost flag.

The arbitration-lost flag is raised by any of five events:
- an SDA mismatch on the SCL sampling edge in a transmit bit;
- an SDA mismatch on the SCL sampling edge in the acknowledge slot of a receive byte;
- a START request while the bus is busy;
- a repeated-START request while in slave mode;
- a STOP on the bus that the local master never asked for.

When such a loss happens while the controller acts as master, the block emits a one-cycle pulse telling it to fall back to slave mode.

The controller supplies the value it currently drives on SDA, the phase of the bit in flight, its master/slave mode, one-cycle request strobes and a one-cycle clear strobe. Pad drivers and byte shifting live elsewhere.

Top module: `i2c_bus_monitor`

## Requirements
- R1: A START (SDA going low while SCL stays high) produces a one-cycle `start_det` pulse, seen in the cycle after the third rising clock edge following the pin change. START and STOP pulses never coincide.
- R2: A STOP (SDA going high while SCL stays high) produces a one-cycle `stop_det` pulse with the same latency as R1. An SDA change while SCL is low produces neither pulse.
- R3: `busy` rises together with `start_det` and falls together with `stop_det`; otherwise it holds.
- R4: In phase 2'b01 (address or data transmit), as master, an SCL rising edge that samples SDA low while `sda_drive` is 1 sets `arb_lost`. The same event in slave mode has no effect.
- R5: In phase 2'b10 (acknowledge slot of a receive byte), as master, the same mismatch sets `arb_lost`. In phase 2'b11 (receive data) or 2'b00 (idle) a mismatch is ignored.
- R6: `req_start` while `busy` is 1 sets `arb_lost` on the next clock edge. `req_start` with `busy` at 0 does not.
- R7: `req_rstart` while `is_master` is 0 sets `arb_lost` on the next edge. `req_rstart` as master does not.
- R8: As master, a STOP on the bus sets `arb_lost` unless `req_stop` was strobed since the previous STOP (or in the same cycle).
- R9: `arb_lost` stays at 1 until a `clr_arb` strobe. A new loss in the same cycle as `clr_arb` wins, leaving the flag at 1.
- R10: Each loss event that occurs while `is_master` is 1 produces a one-cycle `to_slave` pulse in the same cycle that `arb_lost` is set. A loss in slave mode gives no pulse.
- R11: After reset, `start_det`, `stop_det`, `busy`, `arb_lost` and `to_slave` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL level from the pad |
| sda_in | input | 1 | Raw SDA level from the pad |
| sda_drive | input | 1 | Value the local master drives on SDA (1 = released) |
| bit_phase | input | 2 | 00 idle, 01 transmit bit, 10 receive-byte acknowledge, 11 receive data |
| is_master | input | 1 | 1 when the controller is in master mode |
| req_start | input | 1 | One-cycle START request strobe |
| req_rstart | input | 1 | One-cycle repeated-START request strobe |
| req_stop | input | 1 | One-cycle STOP request strobe |
| clr_arb | input | 1 | One-cycle strobe clearing the arbitration-lost flag |
| start_det | output | 1 | START seen on the bus (pulse) |
| stop_det | output | 1 | STOP seen on the bus (pulse) |
| busy | output | 1 | Bus held between START and STOP |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| to_slave | output | 1 | Pulse ordering the controller back to slave mode |

## Verification
The clear strobe and a fresh loss event can land in the same clock cycle. The bench provokes this by raising `clr_arb` and `req_start` together on a busy bus, then expects `arb_lost` to read 1 afterwards.

A second overlap is a `req_stop` strobe followed by a bus STOP. Here the STOP must not count as a loss, while a later STOP without a request must. Both are judged from the flag and the `to_slave` pulse at the sample point after the registering edge.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'b00,
    PH_TX     = 2'b01,
    PH_ACK_RX = 2'b10,
    PH_RX     = 2'b11
  } phase_e;
endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    logic [WIDTH-1:0] stg_d;
    if (i == 0) begin : g_first
      always_comb stg_d = din;
    end else begin : g_rest
      always_comb stg_d = stg_q[i-1];
    end
    // idle bus lines are high, so reset to ones to avoid a false edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[i] <= '1;
      else        stg_q[i] <= stg_d;
    end
  end

  assign dout = stg_q[LAST];
endmodule

// File: rtl/i2cmon_cond.sv
module i2cmon_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic start_det,
  output logic stop_det,
  output logic busy
);
  logic scl_p_q, sda_p_q;
  logic start_q, stop_q, busy_q;
  logic busy_en, busy_d;

  always_comb begin
    start_ev = scl_p_q & scl_s & sda_p_q & ~sda_s;
    stop_ev  = scl_p_q & scl_s & ~sda_p_q & sda_s;
    scl_rise = ~scl_p_q & scl_s;
    busy_en  = start_ev | stop_ev;
    busy_d   = start_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      scl_p_q <= scl_s;
      sda_p_q <= sda_s;
      start_q <= start_ev;
      stop_q  <= stop_ev;
      if (busy_en) busy_q <= busy_d;
    end
  end

  assign start_det = start_q;
  assign stop_det  = stop_q;
  assign busy      = busy_q;
endmodule

// File: rtl/i2cmon_arb.sv
module i2cmon_arb
  import i2cmon_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   scl_rise,
  input  logic   sda_s,
  input  logic   sda_drive,
  input  phase_e phase,
  input  logic   is_master,
  input  logic   req_start,
  input  logic   req_rstart,
  input  logic   req_stop,
  input  logic   stop_ev,
  input  logic   busy,
  input  logic   clr_arb,
  output logic   arb_lost,
  output logic   to_slave
);
  logic arb_q, slv_q, pend_q;
  logic arb_d, slv_d, pend_d;
  logic mism, loss_tx, loss_ack, loss_busy, loss_rs, loss_stop, loss_any;

  always_comb begin
    mism      = scl_rise & sda_drive & ~sda_s & is_master;
    loss_tx   = mism & (phase == PH_TX);
    loss_ack  = mism & (phase == PH_ACK_RX);
    loss_busy = req_start & busy;
    loss_rs   = req_rstart & ~is_master;
    loss_stop = stop_ev & is_master & ~(pend_q | req_stop);
    loss_any  = loss_tx | loss_ack | loss_busy | loss_rs | loss_stop;

    arb_d  = loss_any | (arb_q & ~clr_arb);
    slv_d  = loss_any & is_master;
    pend_d = (pend_q | req_stop) & ~stop_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arb_q  <= 1'b0;
      slv_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      arb_q  <= arb_d;
      slv_q  <= slv_d;
      pend_q <= pend_d;
    end
  end

  assign arb_lost = arb_q;
  assign to_slave = slv_q;
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2cmon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       sda_drive,
  input  logic [1:0] bit_phase,
  input  logic       is_master,
  input  logic       req_start,
  input  logic       req_rstart,
  input  logic       req_stop,
  input  logic       clr_arb,
  output logic       start_det,
  output logic       stop_det,
  output logic       busy,
  output logic       arb_lost,
  output logic       to_slave
);
  localparam int unsigned LINES = 2;

  logic [LINES-1:0] pins_s;
  logic scl_s, sda_s;
  logic start_ev, stop_ev, scl_rise;
  logic busy_i;

  i2cmon_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({scl_in, sda_in}),
    .dout (pins_s)
  );

  assign scl_s = pins_s[1];
  assign sda_s = pins_s[0];

  i2cmon_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .scl_rise (scl_rise),
    .start_det(start_det),
    .stop_det (stop_det),
    .busy     (busy_i)
  );

  i2cmon_arb u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .sda_s     (sda_s),
    .sda_drive (sda_drive),
    .phase     (phase_e'(bit_phase)),
    .is_master (is_master),
    .req_start (req_start),
    .req_rstart(req_rstart),
    .req_stop  (req_stop),
    .stop_ev   (stop_ev),
    .busy      (busy_i),
    .clr_arb   (clr_arb),
    .arb_lost  (arb_lost),
    .to_slave  (to_slave)
  );

  assign busy = busy_i;
endmodule

// File: rtl/i2cmon_chk.sv
module i2cmon_chk (
  input logic clk,
  input logic rst_n,
  input logic is_master,
  input logic req_start,
  input logic req_rstart,
  input logic clr_arb,
  input logic start_det,
  input logic stop_det,
  input logic busy,
  input logic arb_lost,
  input logic to_slave
);
  // R1
  start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det && stop_det));
  // R2
  stop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !stop_det);
  // R3
  busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |-> busy);
  // R3
  idle_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |-> !busy);
  // R6
  start_on_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_start && busy) |=> arb_lost);
  // R7
  rstart_slave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rstart && !is_master) |=> arb_lost);
  // R9
  arb_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !clr_arb) |=> arb_lost);
  // R10
  slave_needs_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    to_slave |-> arb_lost);
endmodule

bind i2c_bus_monitor i2cmon_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .is_master (is_master),
  .req_start (req_start),
  .req_rstart(req_rstart),
  .clr_arb   (clr_arb),
  .start_det (start_det),
  .stop_det  (stop_det),
  .busy      (busy),
  .arb_lost  (arb_lost),
  .to_slave  (to_slave)
);

// File: tb/i2c_bus_monitor_bench.sv
module i2c_bus_monitor_bench;
  logic clk = 1'b0;
  logic rst_n, scl_in, sda_in, sda_drive, is_master;
  logic [1:0] bit_phase;
  logic req_start, req_rstart, req_stop, clr_arb;
  logic start_det, stop_det, busy, arb_lost, to_slave;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i2c_bus_monitor u_i2c_bus_monitor (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_drive(sda_drive), .bit_phase(bit_phase), .is_master(is_master),
    .req_start(req_start), .req_rstart(req_rstart), .req_stop(req_stop),
    .clr_arb(clr_arb), .start_det(start_det), .stop_det(stop_det),
    .busy(busy), .arb_lost(arb_lost), .to_slave(to_slave)
  );

  // fields: scl sda drv phase[1:0] master | start stop busy arb slave
  localparam int NV = 14;
  localparam logic [10:0] VEC [NV] = '{
    11'b1_1_1_00_0_0_0_0_0_0,
    11'b1_0_1_00_0_1_0_1_0_0,
    11'b0_0_1_00_0_0_0_1_0_0,
    11'b0_1_1_00_0_0_0_1_0_0,
    11'b1_1_1_01_0_0_0_1_0_0,
    11'b0_0_1_00_0_0_0_1_0_0,
    11'b1_0_1_01_0_0_0_1_0_0,
    11'b1_1_1_00_0_0_1_0_0_0,
    11'b1_0_1_00_1_1_0_1_0_0,
    11'b0_0_1_01_1_0_0_1_0_0,
    11'b1_1_1_01_1_0_0_1_0_0,
    11'b0_1_1_01_1_0_0_1_0_0,
    11'b0_0_1_01_1_0_0_1_0_0,
    11'b1_0_1_01_1_0_0_1_1_1
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic pins(input logic s, input logic d);
    scl_in = s; sda_in = d;
    repeat (3) @(negedge clk);
  endtask

  task automatic strobe_clr();
    clr_arb = 1'b1;
    @(negedge clk);
    clr_arb = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; scl_in = 1'b1; sda_in = 1'b1; sda_drive = 1'b1;
    bit_phase = 2'b00; is_master = 1'b0;
    req_start = 1'b0; req_rstart = 1'b0; req_stop = 1'b0; clr_arb = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 start_det", start_det, 1'b0);
    chk("R11 stop_det", stop_det, 1'b0);
    chk("R11 busy", busy, 1'b0);
    chk("R11 arb_lost", arb_lost, 1'b0);
    chk("R11 to_slave", to_slave, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R3 R4 R10 vector walk
    for (int i = 0; i < NV; i++) begin
      sda_drive = VEC[i][8];
      bit_phase = VEC[i][7:6];
      is_master = VEC[i][5];
      pins(VEC[i][10], VEC[i][9]);
      chk($sformatf("R1 start row %0d", i), start_det, VEC[i][4]);
      chk($sformatf("R2 stop row %0d", i), stop_det, VEC[i][3]);
      chk($sformatf("R3 busy row %0d", i), busy, VEC[i][2]);
      chk($sformatf("R4 arb row %0d", i), arb_lost, VEC[i][1]);
      chk($sformatf("R10 slave row %0d", i), to_slave, VEC[i][0]);
      @(negedge clk);
      chk($sformatf("R1 pulse end row %0d", i), start_det, 1'b0);
    end

    // R9 clear
    strobe_clr();
    chk("R9 cleared", arb_lost, 1'b0);

    // R5 ack slot mismatch
    bit_phase = 2'b10;
    pins(1'b0, 1'b0); @(negedge clk);
    pins(1'b1, 1'b0);
    chk("R5 ack loss", arb_lost, 1'b1);
    chk("R10 ack pulse", to_slave, 1'b1);
    @(negedge clk);
    chk("R10 pulse one cycle", to_slave, 1'b0);
    strobe_clr();

    // R5 receive-data mismatch ignored
    bit_phase = 2'b11;
    pins(1'b0, 1'b0); @(negedge clk);
    pins(1'b1, 1'b0); @(negedge clk);
    chk("R5 rx ignored", arb_lost, 1'b0);
    bit_phase = 2'b00;

    // R6 start on busy bus
    req_start = 1'b1; @(negedge clk); req_start = 1'b0;
    chk("R6 busy start", arb_lost, 1'b1);
    chk("R10 busy start pulse", to_slave, 1'b1);
    strobe_clr();

    // R9 set wins over clear
    req_start = 1'b1; clr_arb = 1'b1; @(negedge clk);
    req_start = 1'b0; clr_arb = 1'b0;
    chk("R9 set wins", arb_lost, 1'b1);
    strobe_clr();

    // R7 repeated start in slave mode
    is_master = 1'b0;
    req_rstart = 1'b1; @(negedge clk); req_rstart = 1'b0;
    chk("R7 slave rstart", arb_lost, 1'b1);
    chk("R10 no pulse in slave", to_slave, 1'b0);
    strobe_clr();
    is_master = 1'b1;
    req_rstart = 1'b1; @(negedge clk); req_rstart = 1'b0;
    chk("R7 master rstart ok", arb_lost, 1'b0);

    // R8 requested stop
    req_stop = 1'b1; @(negedge clk); req_stop = 1'b0;
    pins(1'b1, 1'b1);
    chk("R2 stop seen", stop_det, 1'b1);
    chk("R3 busy cleared", busy, 1'b0);
    chk("R8 requested stop", arb_lost, 1'b0);
    @(negedge clk);

    // R6 start request on idle bus
    req_start = 1'b1; @(negedge clk); req_start = 1'b0;
    chk("R6 idle start ok", arb_lost, 1'b0);

    // R8 unrequested stop
    pins(1'b1, 1'b0);
    chk("R3 busy set", busy, 1'b1);
    @(negedge clk);
    pins(1'b1, 1'b1);
    chk("R8 unrequested stop", arb_lost, 1'b1);
    chk("R10 stop pulse", to_slave, 1'b1);
    @(negedge clk);

    // R11 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 arb reset", arb_lost, 1'b0);
    chk("R11 busy reset", busy, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule